// File: doc/BRIEF.md
# Non-volatile Image Loader with Checksum Gate

This block sits between a single-word read/write port of a serial configuration memory and the rest of the chip. On command it fetches the whole 64-word image one word at a time, keeps a copy in a local word cache, and adds every word into a 16-bit sum. The image counts as good only when that sum equals a fixed constant and when a masked signature field in one control word holds the expected code. A bad sum also wipes the signature field in the cached copy, so the cache cannot later be taken as valid.

Other logic reads configuration words through a lookup port. A lookup is answered from the cache when the cached signature is valid. When it is not, the block first reloads the image and then answers. Indices past the image, and images that fail validation, return zero. A second command recomputes the checksum word from the words below it and writes it back. Any completed write marks the cached signature as cleared, so the next lookup fetches the image again. A 32-bit board number is built from two cached words.

Only one memory request is open at a time. While a sequence is running the block shows busy, and lookups and commands presented in that time are dropped.

Top module: `nvm_image_cache`

## Requirements
- R1: A load issues reads to word indices 0, 1, ... 63 in ascending order. Only one request is open at a time, and its address and direction stay unchanged until the grant.
- R2: The load sums all 64 words modulo 2^16. When the sum equals SUM_CONST (16'hBABA) and (word[SIG_IDX] & 16'hC000) == 16'h4000 (SIG_IDX = 10), the load ends with img_valid = 1 and img_error = 0.
- R3: When the sum differs from SUM_CONST, the signature bits of the cached word SIG_IDX are cleared and the load ends with img_error = 1 and img_valid = 0, even if the fetched signature was valid.
- R4: When the sum is correct but the masked signature differs from 16'h4000, the load ends with img_error = 1 and img_valid = 0.
- R5: A lookup with index >= 64 returns lk_data = 0 with lk_done high one cycle after the request, and no memory access takes place.
- R6: A lookup with index < 64 while img_valid = 1 returns the cached word one cycle after the request, with no memory access.
- R7: A lookup with index < 64 while img_valid = 0 first performs a full load (R1). It then returns the word if that load succeeded, and zero if it failed.
- R8: An update reads words 0 to CK_IDX-1 (CK_IDX = 63) and then writes SUM_CONST minus their 16-bit sum to word CK_IDX. This is the only write the block issues.
- R9: In the cycle after a write is granted, img_valid is 0.
- R10: busy is high for the whole of a load or update. Lookups and commands presented while busy is high are ignored and produce no response and no write.
- R11: board_num equals {word[9], word[8]} from the cache while img_valid = 1, and 0 otherwise.
- R12: After reset, img_valid, img_error, busy, mem_req and lk_done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Pulse: load and validate the image |
| cmd_update | input | 1 | Pulse: recompute and write the checksum word |
| lk_req | input | 1 | Lookup request, accepted while busy is low |
| lk_idx | input | 7 | Lookup word index |
| lk_done | output | 1 | One-cycle lookup response strobe |
| lk_data | output | 16 | Lookup result |
| busy | output | 1 | A load or update sequence is running |
| img_valid | output | 1 | Cached signature field is valid |
| img_error | output | 1 | Last load failed the sum or signature test |
| board_num | output | 32 | Board number from two cached words |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 6 | Memory word index |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | One-cycle grant completing the open request |
| mem_rdata | input | 16 | Read data, valid with the grant |

## Verification
The assertions assume that the memory side raises mem_gnt only while mem_req is high, for one cycle per request, and that it presents read data in the grant cycle. They also assume that lookups and commands are not given in the same cycle. The bench memory model grants every other cycle and only while a request is open. The driver presents one stimulus at a time and waits for busy to fall, except in the deliberate tests of inputs given while busy is high. Those tests check at the ports that nothing happened.

// File: rtl/nvm_img_pkg.sv
package nvm_img_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_JUDGE,
        ST_SUM,
        ST_WRITE
    } seq_state_e;

    typedef struct packed {
        logic  done;
        word_t data;
    } lk_resp_t;

    function automatic logic sig_match(word_t w, word_t mask, word_t code);
        return (w & mask) == code;
    endfunction

endpackage

// File: rtl/nvm_img_store.sv
module nvm_img_store
    import nvm_img_pkg::*;
#(
    parameter int    N_WORDS   = 64,
    parameter int    AW        = 6,
    parameter int    SIG_IDX   = 10,
    parameter word_t SIG_MASK  = 16'hC000,
    parameter word_t SIG_CODE  = 16'h4000,
    parameter int    BRD_LO    = 8,
    parameter int    BRD_HI    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_data,
    input  logic          sig_clear,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_data,
    output logic          sig_valid,
    output logic [31:0]   brd_word
);

    word_t words_q [N_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_WORDS; i++) words_q[i] <= '0;
        end else begin
            if (wr_en) words_q[wr_addr] <= wr_data;
            if (sig_clear) words_q[SIG_IDX] <= words_q[SIG_IDX] & ~SIG_MASK;
        end
    end

    assign rd_data   = words_q[rd_addr];
    assign sig_valid = sig_match(words_q[SIG_IDX], SIG_MASK, SIG_CODE);
    assign brd_word  = sig_valid ? {words_q[BRD_HI], words_q[BRD_LO]} : 32'h0;

    // Clearing the signature always leaves the cache invalid
    assert_sig_clear_R3: assert property (@(posedge clk) disable iff (rst)
        sig_clear |=> !sig_valid);

endmodule

// File: rtl/nvm_img_seq.sv
module nvm_img_seq
    import nvm_img_pkg::*;
#(
    parameter int    N_WORDS   = 64,
    parameter int    AW        = 6,
    parameter int    IW        = 7,
    parameter int    CK_IDX    = 63,
    parameter word_t SUM_CONST = 16'hBABA
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_load,
    input  logic          cmd_update,
    input  logic          lk_req,
    input  logic [IW-1:0] lk_idx,
    input  logic          mem_gnt,
    input  word_t         mem_rdata,
    input  logic          sig_valid,
    input  word_t         rd_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output word_t         mem_wdata,
    output logic          st_wr_en,
    output logic [AW-1:0] st_wr_addr,
    output word_t         st_wr_data,
    output logic          sig_clear,
    output logic [AW-1:0] rd_addr,
    output logic          lk_done,
    output word_t         lk_data,
    output logic          busy,
    output logic          img_error
);

    localparam logic [AW-1:0] LAST_IDX = AW'(N_WORDS - 1);
    localparam logic [AW-1:0] CK_ADDR  = AW'(CK_IDX);
    localparam logic [AW-1:0] SUM_LAST = AW'(CK_IDX - 1);

    seq_state_e     state_q;
    logic [AW-1:0]  cnt_q;
    logic [AW-1:0]  idx_q;
    word_t          sum_q;
    logic           pend_q;
    logic           err_q;
    lk_resp_t       resp_q;
    logic           sum_ok;
    logic           oob;

    assign busy       = state_q != ST_IDLE;
    assign mem_req    = (state_q == ST_LOAD) || (state_q == ST_SUM) || (state_q == ST_WRITE);
    assign mem_we     = state_q == ST_WRITE;
    assign mem_addr   = mem_we ? CK_ADDR : cnt_q;
    assign mem_wdata  = mem_we ? SUM_CONST - sum_q : '0;
    assign st_wr_en   = (state_q == ST_LOAD) && mem_gnt;
    assign st_wr_addr = cnt_q;
    assign st_wr_data = mem_rdata;
    assign sum_ok     = sum_q == SUM_CONST;
    assign sig_clear  = ((state_q == ST_JUDGE) && !sum_ok) || ((state_q == ST_WRITE) && mem_gnt);
    assign rd_addr    = (state_q == ST_IDLE) ? lk_idx[AW-1:0] : idx_q;
    assign oob        = lk_idx >= IW'(N_WORDS);
    assign lk_done    = resp_q.done;
    assign lk_data    = resp_q.data;
    assign img_error  = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sum_q   <= '0;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
            resp_q  <= '0;
        end else begin
            resp_q.done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    sum_q <= '0;
                    if (cmd_load) begin
                        pend_q  <= 1'b0;
                        state_q <= ST_LOAD;
                    end else if (cmd_update) begin
                        state_q <= (CK_IDX == 0) ? ST_WRITE : ST_SUM;
                    end else if (lk_req) begin
                        if (oob) begin
                            resp_q <= '{done: 1'b1, data: '0};
                        end else if (sig_valid) begin
                            resp_q <= '{done: 1'b1, data: rd_data};
                        end else begin
                            pend_q  <= 1'b1;
                            idx_q   <= lk_idx[AW-1:0];
                            state_q <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    if (mem_gnt) begin
                        sum_q <= sum_q + mem_rdata;
                        if (cnt_q == LAST_IDX) state_q <= ST_JUDGE;
                        else                   cnt_q   <= cnt_q + 1'b1;
                    end
                end
                ST_JUDGE: begin
                    err_q <= !(sum_ok && sig_valid);
                    if (pend_q) begin
                        resp_q <= '{done: 1'b1, data: (sum_ok && sig_valid) ? rd_data : '0};
                    end
                    pend_q  <= 1'b0;
                    state_q <= ST_IDLE;
                end
                ST_SUM: begin
                    if (mem_gnt) begin
                        sum_q <= sum_q + mem_rdata;
                        if (cnt_q == SUM_LAST) state_q <= ST_WRITE;
                        else                   cnt_q   <= cnt_q + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (mem_gnt) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // An open request keeps its target until granted
    assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // Loads walk the image in ascending order
    assert_load_order_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD && mem_gnt && cnt_q != LAST_IDX) |=> (mem_addr == $past(mem_addr) + 1'b1));

    // Writes only ever target the checksum word
    assert_wr_target_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr == CK_ADDR));

    // Out-of-range lookups answer zero on the next cycle
    assert_oob_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !busy && oob && !cmd_load && !cmd_update) |=> (lk_done && lk_data == '0 && !mem_req));

    // Nothing is answered while a sequence is running
    assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && state_q != ST_JUDGE) |=> !lk_done);

endmodule

// File: rtl/nvm_image_cache.sv
module nvm_image_cache
    import nvm_img_pkg::*;
#(
    parameter int    N_WORDS   = 64,
    parameter word_t SUM_CONST = 16'hBABA,
    parameter int    CK_IDX    = 63,
    parameter int    SIG_IDX   = 10,
    parameter word_t SIG_MASK  = 16'hC000,
    parameter word_t SIG_CODE  = 16'h4000,
    parameter int    BRD_LO    = 8,
    parameter int    BRD_HI    = 9,
    localparam int   AW        = $clog2(N_WORDS),
    localparam int   IW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_load,
    input  logic          cmd_update,
    input  logic          lk_req,
    input  logic [IW-1:0] lk_idx,
    output logic          lk_done,
    output logic [15:0]   lk_data,
    output logic          busy,
    output logic          img_valid,
    output logic          img_error,
    output logic [31:0]   board_num,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic [15:0]   mem_rdata
);

    logic          st_wr_en;
    logic [AW-1:0] st_wr_addr;
    word_t         st_wr_data;
    logic          sig_clear;
    logic [AW-1:0] rd_addr;
    word_t         rd_data;
    logic          sig_valid;

    nvm_img_seq #(
        .N_WORDS  (N_WORDS),
        .AW       (AW),
        .IW       (IW),
        .CK_IDX   (CK_IDX),
        .SUM_CONST(SUM_CONST)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_load  (cmd_load),
        .cmd_update(cmd_update),
        .lk_req    (lk_req),
        .lk_idx    (lk_idx),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .sig_valid (sig_valid),
        .rd_data   (rd_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .st_wr_en  (st_wr_en),
        .st_wr_addr(st_wr_addr),
        .st_wr_data(st_wr_data),
        .sig_clear (sig_clear),
        .rd_addr   (rd_addr),
        .lk_done   (lk_done),
        .lk_data   (lk_data),
        .busy      (busy),
        .img_error (img_error)
    );

    nvm_img_store #(
        .N_WORDS (N_WORDS),
        .AW      (AW),
        .SIG_IDX (SIG_IDX),
        .SIG_MASK(SIG_MASK),
        .SIG_CODE(SIG_CODE),
        .BRD_LO  (BRD_LO),
        .BRD_HI  (BRD_HI)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (st_wr_en),
        .wr_addr  (st_wr_addr),
        .wr_data  (st_wr_data),
        .sig_clear(sig_clear),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sig_valid(sig_valid),
        .brd_word (board_num)
    );

    assign img_valid = sig_valid;

    // A granted write leaves the cache invalid on the next cycle
    assert_wr_inval_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_gnt) |=> !img_valid);

endmodule

// File: tb/nvm_image_cache_tb_top.sv
`timescale 1ns/1ps
module nvm_image_cache_tb_top;

    localparam logic [15:0] SUM_C  = 16'hBABA;
    localparam int          SIGI   = 10;
    localparam int          NW     = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_load = 1'b0, cmd_update = 1'b0, lk_req = 1'b0;
    logic [6:0]  lk_idx = '0;
    logic        lk_done, busy, img_valid, img_error, mem_req, mem_we;
    logic [15:0] lk_data, mem_wdata;
    logic [31:0] board_num;
    logic [5:0]  mem_addr;
    logic        mem_gnt = 1'b0;
    logic [15:0] mem_rdata = '0;

    logic [15:0] mem [NW];
    int          n_reads = 0, n_writes = 0;
    int          rd_log [NW];
    int          n_checks = 0, n_errors = 0;
    logic [15:0] exp_q [$];
    bit          done_flag = 0;

    always #2.5 clk = ~clk;

    nvm_image_cache dut_i (
        .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_update(cmd_update),
        .lk_req(lk_req), .lk_idx(lk_idx), .lk_done(lk_done), .lk_data(lk_data),
        .busy(busy), .img_valid(img_valid), .img_error(img_error), .board_num(board_num),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sum_below(int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    // Memory model: grants every other cycle while a request is open
    initial begin
        int wait_c = 0;
        forever begin
            @(negedge clk);
            mem_gnt = 1'b0;
            if (mem_req) begin
                if (wait_c == 1) begin
                    wait_c = 0;
                    mem_gnt = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        n_writes++;
                    end else begin
                        mem_rdata = mem[mem_addr];
                        if (n_reads < NW) rd_log[n_reads] = int'(mem_addr);
                        n_reads++;
                    end
                end else begin
                    wait_c++;
                end
            end
        end
    end

    // Monitor: pops expected lookup results as responses appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && lk_done) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected response", 32'(lk_data), 32'hFFFF_FFFF);
                end else begin
                    check("R5/R6/R7 lookup data", 32'(lk_data), 32'(exp_q.pop_front()));
                end
            end
        end
    end

    task automatic lookup(int idx, logic [15:0] exp);
        @(negedge clk);
        lk_req = 1'b1;
        lk_idx = 7'(idx);
        exp_q.push_back(exp);
        @(negedge clk);
        lk_req = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_cmd(bit upd);
        @(negedge clk);
        if (upd) cmd_update = 1'b1; else cmd_load = 1'b1;
        @(negedge clk);
        cmd_update = 1'b0;
        cmd_load = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic build_image();
        for (int i = 0; i < NW; i++) mem[i] = 16'(i * 16'h1357 + 16'hE2C1);
        mem[SIGI] = 16'h4123;
        mem[NW-1] = SUM_C - sum_below(NW - 1);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int r0, w0;
        logic [15:0] tmp;
        build_image();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        check("R12 reset outputs", {27'b0, img_valid, img_error, busy, mem_req, lk_done}, 32'h0);

        // R5 out-of-range with empty cache: zero, no access
        r0 = n_reads;
        lookup(70, 16'h0000);
        check("R5 no access", 32'(n_reads - r0), 32'h0);
        lookup(64, 16'h0000);

        // R7 invalid cache reloads, then answers
        r0 = n_reads;
        lookup(5, mem[5]);
        check("R7 reload reads", 32'(n_reads - r0), 32'(NW));
        begin
            int ord_bad = 0;
            for (int k = 0; k < NW; k++) if (rd_log[r0 + k - r0] != k) ord_bad++;
            check("R1 ascending order", 32'(ord_bad), 32'h0);
        end
        check("R2 valid after good load", {31'b0, img_valid}, 32'h1);
        check("R2 no error", {31'b0, img_error}, 32'h0);

        // R6 cached lookup, no access
        r0 = n_reads;
        lookup(20, mem[20]);
        lookup(63, mem[63]);
        check("R6 no access", 32'(n_reads - r0), 32'h0);

        // R11 board number
        check("R11 board number", board_num, {mem[9], mem[8]});

        // R8 update after a change in the stored image
        mem[3] = mem[3] + 16'h0005;
        r0 = n_reads;
        w0 = n_writes;
        tmp = SUM_C - sum_below(63);
        do_cmd(1'b1);
        check("R8 reads", 32'(n_reads - r0), 32'd63);
        check("R8 one write", 32'(n_writes - w0), 32'd1);
        check("R8 checksum word", 32'(mem[63]), 32'(tmp));
        check("R9 invalid after write", {31'b0, img_valid}, 32'h0);
        check("R11 zero while invalid", board_num, 32'h0);

        // R7 reload after invalidation picks up new data
        lookup(3, mem[3]);
        check("R7 valid again", {31'b0, img_valid}, 32'h1);

        // R3 bad sum with a good signature
        mem[7] = mem[7] ^ 16'h0100;
        do_cmd(1'b0);
        check("R3 error set", {31'b0, img_error}, 32'h1);
        check("R3 signature cleared", {31'b0, img_valid}, 32'h0);
        r0 = n_reads;
        lookup(4, 16'h0000);
        check("R7 failed reload reads", 32'(n_reads - r0), 32'(NW));

        // R10 inputs during busy are ignored
        build_image();
        mem[7] = mem[7] ^ 16'h0100;
        w0 = n_writes;
        @(negedge clk);
        cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 busy during load", {31'b0, busy}, 32'h1);
        lk_req = 1'b1;
        lk_idx = 7'd2;
        cmd_update = 1'b1;
        @(negedge clk);
        lk_req = 1'b0;
        cmd_update = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R10 no write", 32'(n_writes - w0), 32'h0);
        check("R3 load still fails", {31'b0, img_error}, 32'h1);

        // R2 good image after correction
        mem[7] = mem[7] ^ 16'h0100;
        do_cmd(1'b0);
        check("R2 valid", {30'b0, img_valid, img_error}, 32'h2);

        // R4 good sum, bad signature
        mem[SIGI] = 16'h8123;
        mem[NW-1] = SUM_C - sum_below(NW - 1);
        do_cmd(1'b0);
        check("R4 error", {30'b0, img_valid, img_error}, 32'h1);
        lookup(12, 16'h0000);
        lookup(SIGI, 16'h0000);

        repeat (4) @(negedge clk);
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule